// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Controller

This block makes the hazard decisions for a single-issue, in-order 32-bit pipeline. The pipeline is made of seven functional units: fetch, decode, register read, branch resolution, ALU operand select, ALU and memory/writeback. A parameter vector places each unit in a pipeline stage. The controller does not carry data. It looks at the destination register, write enable, load flag and valid bit of the instruction in each stage, at the source registers of the instructions at the two mux points, and at the branch outcome. From these it drives forwarding mux selects, a stall with a freeze mask and a bubble mask, a squash mask, and the next-PC select.

There are two forwarding mux points. The first sits after the register-file read, in the register-read stage. The second sits at the ALU operand select, in the operand-select stage. Each can take the register value, the ALU output or the writeback value. Loads complete through a memory handshake: a load in the writeback stage has its data only in a cycle where the memory response is present. The parameter vector packs seven 3-bit fields, unit 0 (fetch) in the lowest bits through unit 6 (writeback) in the highest, each giving a 1-based stage number. The stage of the writeback unit sets the stage count. Bit i of every per-stage bus belongs to stage i+1; a higher stage holds an older instruction.

Top module: `hz_ctrl`

## Requirements
- R1: A valid source operand (source valid, consumer stage valid) whose register matches the destination of a valid, writing producer in an older (higher-numbered) stage is forwarded. Select encoding is 0 = register file, 1 = ALU output, 2 = writeback.
- R2: Register 0 is never a match. A source of 0 gives select 0 and no stall.
- R3: When several older producers match one source, the youngest wins (lowest stage number above the consumer stage).
- R4: Path choice is the same at both mux points. A winning producer in the writeback stage gives 2, unless it is a load with no response. A non-load winner in the ALU stage (when that stage differs from writeback) gives 1.
- R5: A winner that no path can serve gives select 0 and raises stall. This covers any other stage, a load in the ALU stage, and a load in writeback without a response.
- R6: On a stall, C is the highest consumer stage with a hazard. Freeze bits are set for stages 1..C and a single bubble bit for stage C+1. The PC select is 1 (hold).
- R7: A load in writeback stalls its consumer in every cycle without a memory response. In the cycle the response is present, the stall clears and select is 2.
- R8: A resolved mispredict sets squash bits for every stage below the branch stage and PC select 2 (redirect). A correctly predicted branch squashes nothing.
- R9: In a mispredict cycle, stall, freeze and bubble are all zero even if a hazard exists.
- R10: With no valid instructions, all selects, masks and the stall are 0 and the PC select is 0 (sequential).
- R11: With every unit in stage 1, nothing is ever forwarded or stalled.
- R12: An invalid consumer, an unused source, an invalid producer or a non-writing producer never causes a forward or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stg_vld | input | NS | Per-stage instruction valid |
| stg_we | input | NS | Per-stage register write enable |
| stg_load | input | NS | Per-stage instruction is a load |
| stg_rd | input | NS x AW | Per-stage destination register |
| rr_src | input | 2 x AW | Source registers of the register-read stage instruction |
| rr_use | input | 2 | Source used flags, register-read stage |
| ops_src | input | 2 x AW | Source registers of the operand-select stage instruction |
| ops_use | input | 2 | Source used flags, operand-select stage |
| ld_rsp_ok | input | 1 | Memory response present for the writeback-stage load |
| br_valid | input | 1 | Branch resolved this cycle |
| br_mispredict | input | 1 | Resolved branch was mispredicted |
| rr_fwd | output | 2 x 2 | Mux select after register-file read, per operand |
| ops_fwd | output | 2 x 2 | Mux select at operand select, per operand |
| stall | output | 1 | Data hazard stall |
| hold | output | NS | Freeze mask per stage |
| bubble | output | NS | Bubble insertion mask per stage |
| squash | output | NS | Wrong-path squash mask per stage |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 hold, 2 redirect |

## Verification
The bench checks youngest-producer priority with two matching producers. A design that picked the older one would forward stale data, and the select would read 2 instead of 1. It checks register 0, and non-writing and invalid producers, because a loose match would raise false forwards or stalls. It runs a load in writeback across cycles without and then with a response, and puts a load in the ALU stage: a wrong design would forward data that does not exist yet, or never release the stall. Finally it puts a mispredict in the same cycle as a hazard and drives an all-in-one-stage instance, where a wrong priority would freeze the wrong-path instructions and a wrong stage decode would stall a datapath that has no older producers.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int UNITS = 7;
    localparam int SW    = 3;

    localparam int U_FETCH  = 0;
    localparam int U_DEC    = 1;
    localparam int U_RREAD  = 2;
    localparam int U_BRANCH = 3;
    localparam int U_OPSEL  = 4;
    localparam int U_ALU    = 5;
    localparam int U_WB     = 6;

    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_ALU = 2'd1,
        FWD_WB  = 2'd2
    } fwd_sel_e;

    typedef enum logic [1:0] {
        PC_SEQ   = 2'd0,
        PC_HOLD  = 2'd1,
        PC_REDIR = 2'd2
    } pc_sel_e;

    function automatic int unit_stage(input logic [UNITS*SW-1:0] vec, input int u);
        return int'(vec[u*SW +: SW]);
    endfunction
endpackage

// File: rtl/hz_fwd_point.sv
module hz_fwd_point
    import hz_pkg::*;
#(
    parameter int NS    = 5,
    parameter int AW    = 5,
    parameter int C     = 3,
    parameter int S_ALU = 4,
    parameter int S_WB  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NS-1:0]          stg_vld,
    input  logic [NS-1:0]          stg_we,
    input  logic [NS-1:0]          stg_load,
    input  logic [NS-1:0][AW-1:0]  stg_rd,
    input  logic                   cons_vld,
    input  logic                   src_use,
    input  logic [AW-1:0]          src,
    input  logic                   ld_ok,
    output logic [1:0]             fwd_sel,
    output logic                   hazard
);
    typedef struct packed {
        logic [1:0] sel;
        logic       haz;
    } pt_t;

    pt_t pt_d;

    always_comb begin
        logic hit;
        int   ps;
        hit  = 1'b0;
        ps   = 1;
        pt_d = '0;
        // descending scan: the last hit kept is the youngest older producer (R3)
        for (int p = NS; p >= 1; p--) begin
            if (p > C && stg_vld[p-1] && stg_we[p-1] &&
                stg_rd[p-1] == src && src != '0) begin
                hit = 1'b1;
                ps  = p;
            end
        end
        if (cons_vld && src_use && hit) begin
            if (ps == S_WB) begin
                if (!stg_load[ps-1] || ld_ok) pt_d.sel = FWD_WB;
                else                          pt_d.haz = 1'b1;
            end else if (ps == S_ALU && !stg_load[ps-1]) begin
                pt_d.sel = FWD_ALU;
            end else begin
                pt_d.haz = 1'b1;
            end
        end
    end

    assign fwd_sel = pt_d.sel;
    assign hazard  = pt_d.haz;

    p_x0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (fwd_sel == FWD_RF && !hazard));

    p_idle_operand_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cons_vld || !src_use) |-> (fwd_sel == FWD_RF && !hazard));

    p_stall_no_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> (fwd_sel == FWD_RF));
endmodule

// File: rtl/hz_squash.sv
module hz_squash
    import hz_pkg::*;
#(
    parameter int NS   = 5,
    parameter int S_BR = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          br_valid,
    input  logic          br_mispredict,
    output logic [NS-1:0] squash,
    output logic          redirect
);
    typedef struct packed {
        logic [NS-1:0] mask;
        logic          redir;
    } sq_t;

    sq_t sq_d;

    always_comb begin
        sq_d       = '0;
        sq_d.redir = br_valid && br_mispredict;
        for (int s = 0; s < NS; s++) begin
            sq_d.mask[s] = sq_d.redir && (s + 1 < S_BR);
        end
    end

    assign squash   = sq_d.mask;
    assign redirect = sq_d.redir;

    // branch stage and older stages are never squashed
    p_keep_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((squash >> (S_BR - 1)) == '0));

    p_no_squash_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_valid && br_mispredict) |-> (squash == '0 && !redirect));
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter logic [UNITS*SW-1:0] UNIT_STAGE = {3'd5, 3'd4, 3'd3, 3'd3, 3'd2, 3'd2, 3'd1},
    parameter int                  AW         = 5
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic [unit_stage(UNIT_STAGE, U_WB)-1:0]           stg_vld,
    input  logic [unit_stage(UNIT_STAGE, U_WB)-1:0]           stg_we,
    input  logic [unit_stage(UNIT_STAGE, U_WB)-1:0]           stg_load,
    input  logic [unit_stage(UNIT_STAGE, U_WB)-1:0][AW-1:0]   stg_rd,
    input  logic [1:0][AW-1:0]                                rr_src,
    input  logic [1:0]                                        rr_use,
    input  logic [1:0][AW-1:0]                                ops_src,
    input  logic [1:0]                                        ops_use,
    input  logic                                              ld_rsp_ok,
    input  logic                                              br_valid,
    input  logic                                              br_mispredict,
    output logic [1:0][1:0]                                   rr_fwd,
    output logic [1:0][1:0]                                   ops_fwd,
    output logic                                              stall,
    output logic [unit_stage(UNIT_STAGE, U_WB)-1:0]           hold,
    output logic [unit_stage(UNIT_STAGE, U_WB)-1:0]           bubble,
    output logic [unit_stage(UNIT_STAGE, U_WB)-1:0]           squash,
    output logic [1:0]                                        pc_sel
);
    localparam int NS    = unit_stage(UNIT_STAGE, U_WB);
    localparam int S_RR  = unit_stage(UNIT_STAGE, U_RREAD);
    localparam int S_BR  = unit_stage(UNIT_STAGE, U_BRANCH);
    localparam int S_OPS = unit_stage(UNIT_STAGE, U_OPSEL);
    localparam int S_ALU = unit_stage(UNIT_STAGE, U_ALU);
    localparam int S_WB  = NS;

    logic [1:0] rr_haz;
    logic [1:0] ops_haz;
    logic       redirect;

    generate
        for (genvar k = 0; k < 2; k++) begin : g_opnd
            hz_fwd_point #(
                .NS(NS), .AW(AW), .C(S_RR), .S_ALU(S_ALU), .S_WB(S_WB)
            ) u_rr (
                .clk(clk), .rst_n(rst_n),
                .stg_vld(stg_vld), .stg_we(stg_we), .stg_load(stg_load), .stg_rd(stg_rd),
                .cons_vld(stg_vld[S_RR-1]), .src_use(rr_use[k]), .src(rr_src[k]),
                .ld_ok(ld_rsp_ok), .fwd_sel(rr_fwd[k]), .hazard(rr_haz[k])
            );
            hz_fwd_point #(
                .NS(NS), .AW(AW), .C(S_OPS), .S_ALU(S_ALU), .S_WB(S_WB)
            ) u_ops (
                .clk(clk), .rst_n(rst_n),
                .stg_vld(stg_vld), .stg_we(stg_we), .stg_load(stg_load), .stg_rd(stg_rd),
                .cons_vld(stg_vld[S_OPS-1]), .src_use(ops_use[k]), .src(ops_src[k]),
                .ld_ok(ld_rsp_ok), .fwd_sel(ops_fwd[k]), .hazard(ops_haz[k])
            );
        end
    endgenerate

    hz_squash #(.NS(NS), .S_BR(S_BR)) u_squash (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_mispredict(br_mispredict),
        .squash(squash), .redirect(redirect)
    );

    typedef struct packed {
        logic          stall;
        logic [NS-1:0] hold;
        logic [NS-1:0] bubble;
        logic [1:0]    pc;
    } ctl_t;

    ctl_t ctl_d;

    always_comb begin
        int cs;
        ctl_d = '0;
        cs    = 0;
        if (|rr_haz)  cs = S_RR;
        if (|ops_haz) cs = S_OPS;   // the later point freezes more
        if (redirect) begin
            ctl_d.pc = PC_REDIR;    // squash beats stall
        end else if (cs != 0) begin
            ctl_d.stall = 1'b1;
            ctl_d.pc    = PC_HOLD;
            for (int s = 0; s < NS; s++) begin
                ctl_d.hold[s]   = (s + 1 <= cs);
                ctl_d.bubble[s] = (s == cs);
            end
        end
    end

    assign stall  = ctl_d.stall;
    assign hold   = ctl_d.hold;
    assign bubble = ctl_d.bubble;
    assign pc_sel = ctl_d.pc;

    p_squash_beats_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_mispredict) |->
            (!stall && hold == '0 && bubble == '0 && pc_sel == PC_REDIR));

    p_single_bubble_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bubble));

    p_stall_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (hold[0] && $countones(bubble) == 1 && pc_sel == PC_HOLD));

    p_squash_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (squash != '0) |-> (pc_sel == PC_REDIR));
endmodule

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [4:0]      stg_vld, stg_we, stg_load;
    logic [4:0][4:0] stg_rd;
    logic [1:0][4:0] rr_src, ops_src;
    logic [1:0]      rr_use, ops_use;
    logic            ld_rsp_ok, br_valid, br_mispredict;
    logic [1:0][1:0] rr_fwd, ops_fwd;
    logic            stall;
    logic [4:0]      hold, bubble, squash;
    logic [1:0]      pc_sel;

    hz_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .stg_vld(stg_vld), .stg_we(stg_we), .stg_load(stg_load), .stg_rd(stg_rd),
        .rr_src(rr_src), .rr_use(rr_use), .ops_src(ops_src), .ops_use(ops_use),
        .ld_rsp_ok(ld_rsp_ok), .br_valid(br_valid), .br_mispredict(br_mispredict),
        .rr_fwd(rr_fwd), .ops_fwd(ops_fwd), .stall(stall), .hold(hold),
        .bubble(bubble), .squash(squash), .pc_sel(pc_sel)
    );

    // all units in stage 1 (R11)
    logic [0:0]      f_one;
    logic [0:0][4:0] f_rd;
    logic [1:0][4:0] f_src;
    logic [1:0][1:0] f_rr_fwd, f_ops_fwd;
    logic            f_stall;
    logic [0:0]      f_hold, f_bubble, f_squash;
    logic [1:0]      f_pc;
    assign f_one = 1'b1;
    assign f_rd  = ops_src[0];
    assign f_src = {ops_src[0], ops_src[0]};

    hz_ctrl #(.UNIT_STAGE({7{3'd1}})) u_flat (
        .clk(clk), .rst_n(rst_n),
        .stg_vld(f_one), .stg_we(f_one), .stg_load(1'b0), .stg_rd(f_rd),
        .rr_src(f_src), .rr_use(2'b11), .ops_src(f_src), .ops_use(2'b11),
        .ld_rsp_ok(1'b0), .br_valid(1'b0), .br_mispredict(1'b0),
        .rr_fwd(f_rr_fwd), .ops_fwd(f_ops_fwd), .stall(f_stall), .hold(f_hold),
        .bubble(f_bubble), .squash(f_squash), .pc_sel(f_pc)
    );

    typedef struct {
        string      tag;
        logic [1:0] rr0, rr1, op0, op1;
        logic       stl;
        logic [4:0] hld, bub, sq;
        logic [1:0] pc;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input string tag, input logic [1:0] rr0, input logic [1:0] rr1,
                        input logic [1:0] op0, input logic [1:0] op1, input logic stl,
                        input logic [4:0] hld, input logic [4:0] bub, input logic [4:0] sq,
                        input logic [1:0] pc);
        exp_t e;
        e.tag = tag; e.rr0 = rr0; e.rr1 = rr1; e.op0 = op0; e.op1 = op1;
        e.stl = stl; e.hld = hld; e.bub = bub; e.sq = sq; e.pc = pc;
        q.push_back(e);
    endtask

    task automatic clear_all();
        stg_vld = '0; stg_we = '0; stg_load = '0; stg_rd = '0;
        rr_src = '0; rr_use = '0; ops_src = '0; ops_use = '0;
        ld_rsp_ok = 1'b0; br_valid = 1'b0; br_mispredict = 1'b0;
    endtask

    // stage s is 1-based; bus bit s-1
    task automatic prod(input int s, input logic [4:0] rd, input logic ld);
        stg_vld[s-1] = 1'b1; stg_we[s-1] = 1'b1; stg_rd[s-1] = rd; stg_load[s-1] = ld;
    endtask

    // monitor: compares a quarter period after inputs change
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "rr_fwd0",  {6'd0, rr_fwd[0]},  {6'd0, e.rr0});
                chk(e.tag, "rr_fwd1",  {6'd0, rr_fwd[1]},  {6'd0, e.rr1});
                chk(e.tag, "ops_fwd0", {6'd0, ops_fwd[0]}, {6'd0, e.op0});
                chk(e.tag, "ops_fwd1", {6'd0, ops_fwd[1]}, {6'd0, e.op1});
                chk(e.tag, "stall",    {7'd0, stall},      {7'd0, e.stl});
                chk(e.tag, "hold",     {3'd0, hold},       {3'd0, e.hld});
                chk(e.tag, "bubble",   {3'd0, bubble},     {3'd0, e.bub});
                chk(e.tag, "squash",   {3'd0, squash},     {3'd0, e.sq});
                chk(e.tag, "pc_sel",   {6'd0, pc_sel},     {6'd0, e.pc});
                chk("R11", "flat stall", {7'd0, f_stall}, 8'd0);
                chk("R11", "flat fwd", {4'd0, f_rr_fwd, f_ops_fwd}, 8'd0);
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        push("R10 idle in reset", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);
        @(negedge clk); rst_n = 1'b1;
        push("R10 idle", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R1 R4: ALU-stage producer to operand select
        @(negedge clk); clear_all();
        stg_vld[2] = 1'b1; ops_src[0] = 5'd5; ops_use[0] = 1'b1; prod(4, 5'd5, 1'b0);
        push("R1 R4 alu path", 0, 0, 1, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R4: writeback producer to both points
        @(negedge clk); clear_all();
        stg_vld[1] = 1'b1; stg_vld[2] = 1'b1;
        rr_src[0] = 5'd7; rr_use[0] = 1'b1; ops_src[1] = 5'd7; ops_use[1] = 1'b1;
        prod(5, 5'd7, 1'b0);
        push("R4 wb path", 2, 0, 0, 2, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R3: youngest of two matches
        @(negedge clk); clear_all();
        stg_vld[1] = 1'b1; stg_vld[2] = 1'b1;
        rr_src[1] = 5'd9; rr_use[1] = 1'b1; ops_src[0] = 5'd9; ops_use[0] = 1'b1;
        prod(4, 5'd9, 1'b0); prod(5, 5'd9, 1'b0);
        push("R3 youngest wins", 0, 1, 1, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R2: register 0
        @(negedge clk); clear_all();
        stg_vld[2] = 1'b1; ops_src[0] = 5'd0; ops_use[0] = 1'b1; prod(4, 5'd0, 1'b1);
        push("R2 x0 ignored", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R12: non-writing and invalid producers
        @(negedge clk); clear_all();
        stg_vld[2] = 1'b1; ops_src[0] = 5'd6; ops_use[0] = 1'b1;
        prod(4, 5'd6, 1'b0); stg_we[3] = 1'b0;
        stg_we[4] = 1'b1; stg_rd[4] = 5'd6;
        push("R12 producer gated", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R12: invalid consumer
        @(negedge clk); clear_all();
        ops_src[0] = 5'd6; ops_use[0] = 1'b1; prod(4, 5'd6, 1'b1);
        push("R12 consumer invalid", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R5 R6: register-read hazard on a stage-3 producer
        @(negedge clk); clear_all();
        stg_vld[1] = 1'b1; rr_src[0] = 5'd8; rr_use[0] = 1'b1; prod(3, 5'd8, 1'b0);
        push("R5 R6 rr stall", 0, 0, 0, 0, 1, 5'b00011, 5'b00100, 5'b00000, 1);

        // R5: load in ALU stage
        @(negedge clk); clear_all();
        stg_vld[2] = 1'b1; ops_src[0] = 5'd4; ops_use[0] = 1'b1; prod(4, 5'd4, 1'b1);
        push("R5 load in alu", 0, 0, 0, 0, 1, 5'b00111, 5'b01000, 5'b00000, 1);

        // R7: load in writeback, no response, then response
        @(negedge clk); clear_all();
        stg_vld[2] = 1'b1; ops_src[1] = 5'd4; ops_use[1] = 1'b1; prod(5, 5'd4, 1'b1);
        push("R7 load wait", 0, 0, 0, 0, 1, 5'b00111, 5'b01000, 5'b00000, 1);
        @(negedge clk);
        push("R7 load wait again", 0, 0, 0, 0, 1, 5'b00111, 5'b01000, 5'b00000, 1);
        @(negedge clk); ld_rsp_ok = 1'b1;
        push("R7 load released", 0, 0, 0, 2, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        // R6: both points hazard, later point sets the freeze
        @(negedge clk); clear_all();
        stg_vld[1] = 1'b1; rr_src[0] = 5'd8; rr_use[0] = 1'b1; prod(3, 5'd8, 1'b0);
        ops_src[0] = 5'd4; ops_use[0] = 1'b1; prod(4, 5'd4, 1'b1);
        push("R6 both points", 0, 0, 0, 0, 1, 5'b00111, 5'b01000, 5'b00000, 1);

        // R8: mispredict
        @(negedge clk); clear_all();
        br_valid = 1'b1; br_mispredict = 1'b1;
        push("R8 mispredict", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00011, 2);

        // R9: mispredict with a hazard
        @(negedge clk); clear_all();
        stg_vld[2] = 1'b1; ops_src[0] = 5'd4; ops_use[0] = 1'b1; prod(4, 5'd4, 1'b1);
        br_valid = 1'b1; br_mispredict = 1'b1;
        push("R9 squash over stall", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00011, 2);

        // R8: correct prediction
        @(negedge clk); clear_all();
        br_valid = 1'b1;
        push("R8 predicted ok", 0, 0, 0, 0, 0, 5'b00000, 5'b00000, 5'b00000, 0);

        @(negedge clk); clear_all();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule